// File: doc/BRIEF.md
# Software-Raised Interrupt Flag Bank

This block holds eight interrupt request flags that only software controls. Each flag has its own one-byte control register on a simple memory-mapped bus with a write strobe, an address, a write byte and a combinational read byte. A set command raises the flag and a clear command lowers it. A raised flag behaves like a peripheral's interrupt request toward a downstream priority controller.

Each flag drives a request line through a fixed-latency pipeline. Each line carries a constant vector number equal to the flag index plus a base. The set bit cannot be read: every read returns it as zero. The flag state appears at the clear bit position. A write that asks for both set and clear leaves the flag set.

Top module: `sirq_bank`

## Requirements
- R1: A synchronous active-high reset clears every flag. After reset all request lines are low and every register reads 0x00.
- R2: A write with bit 1 (the set bit) at 1 raises the flag of the addressed register.
- R3: On read, bit 1 is always 0 and bits 7..2 are always 0.
- R4: On read, bit 0 holds the current state of the addressed flag. The read data is combinational on the address.
- R5: A write with bit 0 (the clear bit) at 1 and bit 1 at 0 lowers the addressed flag.
- R6: A write with both bit 1 and bit 0 at 0 leaves the addressed flag unchanged, whatever bits 7..2 hold.
- R7: A write with both bit 1 and bit 0 at 1 leaves the flag raised, whether it was raised or lowered before.
- R8: A write changes only the flag selected by the address. With the write strobe low, no flag changes.
- R9: Request line i follows flag i with a total latency of four clock edges. A flag changed at edge N shows on the request line after edge N+3, counting the write edge as the first.
- R10: Vector output field i (9 bits wide, field 0 in the lowest bits) is constant at i.
- R11: Reads have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register select |
| wdata | input | 8 | Write byte: bit 1 set, bit 0 clear |
| rdata | output | 8 | Read byte of the addressed register |
| irq_req | output | 8 | Request line per flag |
| irq_vec | output | 72 | Fixed 9-bit vector per request line |

## Verification
The bench targets a write with both command bits high to a flag that is already raised and to one that is lowered. A design that lets the clear win would drop the request there. It writes zeros and junk upper bits to raised flags; a design that decodes a zero as a command would lose state. It writes with the strobe low and to neighbouring addresses, which exposes a wrong address decode as a stray flag change. Every request edge is compared with the flag history exactly four edges back, so a pipeline one stage short or long miscompares on each toggle.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int unsigned NUM_FLAGS = 8;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned VEC_W     = 9;
    localparam int unsigned SET_POS   = 1;
    localparam int unsigned CLR_POS   = 0;
    localparam int unsigned ADDR_W    = $clog2(NUM_FLAGS);

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_LOWER = 2'b01,
        CMD_RAISE = 2'b10,
        CMD_BOTH  = 2'b11
    } flag_cmd_e;
endpackage

// File: rtl/sirq_flag_next.sv
module sirq_flag_next
    import sirq_pkg::*;
(
    input  logic      sel,
    input  flag_cmd_e cmd,
    input  logic      cur,
    output logic      nxt
);
    always_comb begin
        nxt = cur;
        if (sel) begin
            unique case (cmd)
                CMD_RAISE, CMD_BOTH: nxt = 1'b1;
                CMD_LOWER:           nxt = 1'b0;
                default:             nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/sirq_pipe.sv
module sirq_pipe #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = din;
        for (int s = 1; s < int'(STAGES); s++) begin
            st_d.stg[s] = st_q.stg[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout = st_q.stg[STAGES-1];
endmodule

// File: rtl/sirq_readmux.sv
module sirq_readmux #(
    parameter int unsigned NUM    = 8,
    parameter int unsigned AW     = 3,
    parameter int unsigned DW     = 8,
    parameter int unsigned FLAG_P = 0
) (
    input  logic [NUM-1:0] flags,
    input  logic [AW-1:0]  addr,
    output logic [DW-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        rdata[FLAG_P] = flags[addr];
    end
endmodule

// File: rtl/sirq_bank.sv
module sirq_bank
    import sirq_pkg::*;
#(
    parameter int unsigned LATENCY  = 4,
    parameter int unsigned VEC_BASE = 0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_FLAGS-1:0]       irq_req,
    output logic [NUM_FLAGS*VEC_W-1:0] irq_vec
);
    localparam int unsigned PIPE_STAGES = (LATENCY > 1) ? LATENCY - 1 : 1;

    typedef struct packed {
        logic [NUM_FLAGS-1:0] flags;
    } bank_t;

    bank_t     bank_d, bank_q;
    flag_cmd_e cmd;
    logic [NUM_FLAGS-1:0] flag_nxt;
    logic      unused_wdata;

    assign cmd          = flag_cmd_e'({wdata[SET_POS], wdata[CLR_POS]});
    assign unused_wdata = ^wdata;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        sirq_flag_next u_next (
            .sel (wr_en && (addr == ADDR_W'(i))),
            .cmd (cmd),
            .cur (bank_q.flags[i]),
            .nxt (flag_nxt[i])
        );
        assign irq_vec[i*VEC_W +: VEC_W] = VEC_W'(VEC_BASE + i);
    end

    always_comb begin
        bank_d       = bank_q;
        bank_d.flags = flag_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) bank_q <= '0;
        else     bank_q <= bank_d;
    end

    sirq_pipe #(.WIDTH(NUM_FLAGS), .STAGES(PIPE_STAGES)) u_pipe (
        .clk  (clk),
        .rst  (rst),
        .din  (bank_q.flags),
        .dout (irq_req)
    );

    sirq_readmux #(.NUM(NUM_FLAGS), .AW(ADDR_W), .DW(DATA_W), .FLAG_P(CLR_POS)) u_rd (
        .flags (bank_q.flags),
        .addr  (addr),
        .rdata (rdata)
    );
endmodule

// File: rtl/sirq_bank_chk.sv
module sirq_bank_chk
    import sirq_pkg::*;
#(
    parameter int unsigned LATENCY  = 4,
    parameter int unsigned VEC_BASE = 0
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          addr,
    input logic [DATA_W-1:0]          wdata,
    input logic [DATA_W-1:0]          rdata,
    input logic [NUM_FLAGS-1:0]       irq_req,
    input logic [NUM_FLAGS*VEC_W-1:0] irq_vec,
    input logic [NUM_FLAGS-1:0]       flags
);
    always @(negedge clk) begin
        if (!rst) begin
            AST_RD_UPPER_ZERO: assert (rdata[DATA_W-1:1] == '0); // R3
            AST_RD_FLAG: assert (rdata[CLR_POS] == flags[addr]); // R4
        end
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_chk
        AST_RAISE: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == ADDR_W'(i) && wdata[SET_POS]) |=> flags[i]); // R2
        AST_LOWER: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == ADDR_W'(i) && wdata[CLR_POS] && !wdata[SET_POS]) |=> !flags[i]); // R5
        AST_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && addr == ADDR_W'(i) && (wdata[SET_POS] || wdata[CLR_POS])) |=> $stable(flags[i])); // R8
        always @(negedge clk) begin
            AST_VEC_FIXED: assert (irq_vec[i*VEC_W +: VEC_W] == VEC_W'(VEC_BASE + i)); // R10
        end
    end

    if (LATENCY == 4) begin : g_lat
        AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (rst)
            irq_req == $past(flags, 3)); // R9
    end
endmodule

bind sirq_bank sirq_bank_chk #(.LATENCY(LATENCY), .VEC_BASE(VEC_BASE)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_req(irq_req), .irq_vec(irq_vec), .flags(bank_q.flags)
);

// File: tb/sim_sirq_bank.sv
module sim_sirq_bank;
    import sirq_pkg::*;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       wr_en = 1'b0;
    logic [ADDR_W-1:0]          addr = '0;
    logic [DATA_W-1:0]          wdata = '0;
    logic [DATA_W-1:0]          rdata;
    logic [NUM_FLAGS-1:0]       irq_req;
    logic [NUM_FLAGS*VEC_W-1:0] irq_vec;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [NUM_FLAGS-1:0] model = '0;
    logic [NUM_FLAGS-1:0] hist [4];
    bit done = 1'b0;

    sirq_bank u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                  .rdata(rdata), .irq_req(irq_req), .irq_vec(irq_vec));

    always #10 clk = ~clk; // 50 MHz

    function automatic logic next_flag(logic cur, logic [DATA_W-1:0] d);
        if (d[1])      return 1'b1;
        else if (d[0]) return 1'b0;
        else           return cur;
    endfunction

    function automatic logic [DATA_W-1:0] exp_read(logic [NUM_FLAGS-1:0] f, logic [ADDR_W-1:0] a);
        return {{(DATA_W-1){1'b0}}, f[a]};
    endfunction

    task automatic check(string req, logic [NUM_FLAGS*VEC_W-1:0] act, logic [NUM_FLAGS*VEC_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at negedge, check read comb, clock, update model, check request lines
    task automatic step(logic we, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, string req);
        wr_en = we; addr = a; wdata = d;
        #1;
        check({req, "/R4 R3 read"}, rdata, exp_read(model, a));
        @(posedge clk);
        if (we) model[a] = next_flag(model[a], d);
        for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = model;
        @(negedge clk);
        check("R9 request latency", irq_req, hist[3]);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5a17));
        for (int k = 0; k < 4; k++) hist[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 irq after reset", irq_req, '0);
        for (int a = 0; a < NUM_FLAGS; a++) begin
            addr = ADDR_W'(a); #1;
            check("R1 read after reset", rdata, '0);
        end
        // R10 fixed vectors
        for (int i = 0; i < NUM_FLAGS; i++)
            check("R10 vector", irq_vec[i*VEC_W +: VEC_W], VEC_W'(i));

        step(1, 3'd2, 8'h02, "R2 raise");
        step(0, 3'd2, 8'h00, "R2 readback");
        check("R2 flag raised read", rdata, 8'h01);
        step(1, 3'd2, 8'hFC, "R6 zero cmd junk high");
        step(0, 3'd2, 8'h00, "R6 hold");
        check("R6 flag kept", rdata, 8'h01);
        step(1, 3'd2, 8'h03, "R7 both on raised");
        step(1, 3'd5, 8'h03, "R7 both on lowered");
        step(0, 3'd5, 8'h00, "R7 read");
        check("R7 flag set", rdata, 8'h01);
        step(0, 3'd2, 8'h03, "R8 strobe low");
        step(1, 3'd3, 8'h01, "R8 neighbour clear");
        step(0, 3'd2, 8'h00, "R8 read");
        check("R8 flag untouched", rdata, 8'h01);
        step(1, 3'd2, 8'h01, "R5 lower");
        step(0, 3'd2, 8'h00, "R5 read");
        check("R5 flag lowered", rdata, 8'h00);
        for (int k = 0; k < 6; k++) step(0, ADDR_W'(k), 8'h00, "R11 reads only");
        check("R11 flags after reads", irq_req, model);

        for (int n = 0; n < 2000; n++) begin
            logic [DATA_W-1:0] d;
            d = 8'($urandom);
            if (($urandom % 3) == 0) d[1:0] = 2'b00;
            step(1'($urandom % 4 != 0), ADDR_W'($urandom), d, "R2 R5 R7 random");
        end
        for (int k = 0; k < 4; k++) step(0, 3'd0, 8'h00, "R9 drain");

        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        model = '0;
        for (int k = 0; k < 4; k++) hist[k] = '0;
        check("R1 irq after second reset", irq_req, '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule